// File: doc/BRIEF.md
# USB Full-Speed Transmit Serializer

This block turns a stream of bytes into a full-speed USB line signal. The packet source offers bytes with a valid/ready handshake of the UTMI kind. The block runs from a 48 MHz clock and sends one line bit every four clocks, which gives 12 Mbit/s. For each packet it first sends the synchronization byte. It then sends the payload least significant bit first, inserting a zero after any run of six ones, and NRZI-codes the result. The packet ends with two bit times of single-ended zero and one bit time of J. After that the transceiver drive enable is released.

Two line encodings serve the two settings of an external transceiver's mode pin, and the `pin_fmt` input picks between them. In format 0, a single-ended zero is shown with `line_n` high. In format 1, a single-ended zero is shown by driving both lines low, and the pair {`line_n`,`line_p`} = 11 is never produced. The J state is `line_p` high and `line_n` low in both formats.

The controller is a state machine with six states. ST_IDLE moves to ST_SYNC on the clock where `tx_valid` is seen. ST_SYNC moves to ST_DATA when the first byte is taken after the eighth sync bit. If no byte is offered at that point, ST_SYNC moves to ST_EOP_SE0A instead. ST_DATA stays in ST_DATA while further bytes are accepted. It moves to ST_EOP_SE0A when a byte is used up, no stuff bit is pending, and `tx_valid` is low. ST_EOP_SE0A moves to ST_EOP_SE0B, then to ST_EOP_J, and then back to ST_IDLE, one bit time per step.

Top module: `usbfs_tx_serializer`

## Requirements
- R1: Each line symbol is held for exactly 4 clocks. The first symbol of a packet appears at the clock edge on which `tx_valid` is high while idle.
- R2: Every packet begins with the 8 symbols K J K J K J K K, starting from a J line.
- R3: Payload bytes are sent least significant bit first and NRZI-coded: a 0 bit inverts the line level (J and K swap) and a 1 bit keeps it.
- R4: After six consecutive 1 bits, counting from the sync byte onward and across byte boundaries, a 0 bit is inserted. This includes a run that ends on the last payload bit.
- R5: After the last bit, the line shows SE0 for two bit times and then J for one bit time. On the next clock edge `drv_en` goes low, and `drv_en` is high for the whole packet.
- R6: `tx_ready` is high for one clock per accepted byte, and only while `tx_valid` is high. The first byte is taken right after the sync byte. If `tx_valid` is low when a new byte is needed, the packet ends.
- R7: With `pin_fmt`=0, {`line_n`,`line_p`} is 01 for J, 00 for K and 10 for SE0.
- R8: With `pin_fmt`=1, {`line_n`,`line_p`} is 01 for J, 10 for K and 00 for SE0, and is never 11.
- R9: In reset and while idle, `drv_en` is 0, `tx_ready` is 0 and the line shows J (01).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 48 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_fmt | input | 1 | Line encoding select (0 or 1) |
| tx_data | input | 8 | Byte offered for transmission |
| tx_valid | input | 1 | Byte offered; held high for the whole packet |
| tx_ready | output | 1 | Offered byte is taken on this clock |
| line_p | output | 1 | Positive line output to the transceiver |
| line_n | output | 1 | Negative line output to the transceiver |
| drv_en | output | 1 | Transceiver drive enable, high while sending |

## Verification
Packets of 0xFF bytes check stuffing at byte boundaries and across bytes. Packets of zero bytes check that every bit inverts the line, which separates the NRZI rule from a plain level output. A final 0xFC byte forces a stuff bit just before the end-of-packet, and an empty packet checks the early end straight after sync. Seeded random packets of one to five bytes in both line formats compare every symbol, sampled in the first and last clock of its bit time, against a sequence built by a bench function. This catches shifted bit times, swapped encodings and miscounted ready pulses.

// File: rtl/usbfs_tx_pkg.sv
package usbfs_tx_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_DATA,
        ST_EOP_SE0A,
        ST_EOP_SE0B,
        ST_EOP_J
    } tx_state_t;

    typedef enum logic [1:0] {
        SYM_SE0 = 2'd0,
        SYM_J   = 2'd1,
        SYM_K   = 2'd2
    } line_sym_t;

    typedef enum logic [2:0] {
        EK_NONE,
        EK_BIT,
        EK_SE0,
        EK_J,
        EK_REL
    } emit_kind_t;

endpackage

// File: rtl/usbfs_bit_timer.sv
module usbfs_bit_timer #(
    parameter int unsigned CLKS_PER_BIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic bit_end
);
    localparam int unsigned CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    logic [CW-1:0] cnt;

    // Counter rests at zero while idle so every packet starts on a fresh bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign bit_end = run && (cnt == LAST);
endmodule

// File: rtl/usbfs_tx_ctrl.sv
module usbfs_tx_ctrl
    import usbfs_tx_pkg::*;
#(
    parameter int unsigned   STUFF_RUN    = 6,
    parameter logic [BYTE_W-1:0] SYNC_PATTERN = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic              bit_end,
    output logic              run,
    output emit_kind_t        emit_kind,
    output logic              emit_bit
);
    localparam int unsigned RUN_W = $clog2(STUFF_RUN + 1);
    localparam int unsigned REM_W = $clog2(BYTE_W);

    tx_state_t          state, nxt;
    logic [BYTE_W-1:0]  sh;
    logic [REM_W-1:0]   rem;
    logic [RUN_W-1:0]   ones;
    logic [RUN_W-1:0]   ones_base;
    logic               stuff_due;
    logic               load_en;
    logic               shift_en;
    logic [BYTE_W-1:0]  load_val;

    assign stuff_due = (ones == RUN_W'(STUFF_RUN));
    assign ones_base = (state == ST_IDLE) ? '0 : ones;
    assign run       = (state != ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next state and per-clock outputs
    always_comb begin
        nxt       = state;
        emit_kind = EK_NONE;
        emit_bit  = 1'b1;
        tx_ready  = 1'b0;
        load_en   = 1'b0;
        shift_en  = 1'b0;
        load_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (tx_valid) begin
                    nxt       = ST_SYNC;
                    emit_kind = EK_BIT;
                    emit_bit  = SYNC_PATTERN[0];
                    load_en   = 1'b1;
                    load_val  = SYNC_PATTERN;
                end
            end
            ST_SYNC, ST_DATA: begin
                if (bit_end) begin
                    if (stuff_due) begin
                        emit_kind = EK_BIT;
                        emit_bit  = 1'b0;
                    end else if (rem != '0) begin
                        emit_kind = EK_BIT;
                        emit_bit  = sh[0];
                        shift_en  = 1'b1;
                    end else if (tx_valid) begin
                        nxt       = ST_DATA;
                        tx_ready  = 1'b1;
                        emit_kind = EK_BIT;
                        emit_bit  = tx_data[0];
                        load_en   = 1'b1;
                        load_val  = tx_data;
                    end else begin
                        nxt       = ST_EOP_SE0A;
                        emit_kind = EK_SE0;
                    end
                end
            end
            ST_EOP_SE0A: begin
                if (bit_end) begin
                    nxt       = ST_EOP_SE0B;
                    emit_kind = EK_SE0;
                end
            end
            ST_EOP_SE0B: begin
                if (bit_end) begin
                    nxt       = ST_EOP_J;
                    emit_kind = EK_J;
                end
            end
            ST_EOP_J: begin
                if (bit_end) begin
                    nxt       = ST_IDLE;
                    emit_kind = EK_REL;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Shift register, bit counter and run-of-ones counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '0;
            rem  <= '0;
            ones <= '0;
        end else begin
            if (load_en) begin
                sh  <= {1'b0, load_val[BYTE_W-1:1]};
                rem <= REM_W'(BYTE_W - 1);
            end else if (shift_en) begin
                sh  <= {1'b0, sh[BYTE_W-1:1]};
                rem <= rem - REM_W'(1);
            end
            if (emit_kind == EK_BIT) begin
                ones <= emit_bit ? (ones_base + RUN_W'(1)) : '0;
            end else if (emit_kind == EK_REL) begin
                ones <= '0;
            end
        end
    end
endmodule

// File: rtl/usbfs_line_drv.sv
module usbfs_line_drv
    import usbfs_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  emit_kind_t emit_kind,
    input  logic       emit_bit,
    output line_sym_t  sym,
    output logic       oe
);
    logic lvl_j;
    logic next_lvl_j;

    // NRZI: a zero inverts the level, a one keeps it
    always_comb begin
        next_lvl_j = emit_bit ? lvl_j : ~lvl_j;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_j <= 1'b1;
            sym   <= SYM_J;
            oe    <= 1'b0;
        end else begin
            unique case (emit_kind)
                EK_NONE: ;
                EK_BIT: begin
                    lvl_j <= next_lvl_j;
                    sym   <= next_lvl_j ? SYM_J : SYM_K;
                    oe    <= 1'b1;
                end
                EK_SE0: begin
                    sym <= SYM_SE0;
                    oe  <= 1'b1;
                end
                EK_J: begin
                    lvl_j <= 1'b1;
                    sym   <= SYM_J;
                    oe    <= 1'b1;
                end
                EK_REL: begin
                    lvl_j <= 1'b1;
                    sym   <= SYM_J;
                    oe    <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/usbfs_pin_enc.sv
module usbfs_pin_enc
    import usbfs_tx_pkg::*;
(
    input  logic      fmt,
    input  line_sym_t sym,
    output logic      p,
    output logic      n
);
    always_comb begin
        case (sym)
            SYM_J:   {n, p} = 2'b01;
            SYM_K:   {n, p} = fmt ? 2'b10 : 2'b00;
            default: {n, p} = fmt ? 2'b00 : 2'b10;
        endcase
    end
endmodule

// File: rtl/usbfs_tx_serializer.sv
module usbfs_tx_serializer
    import usbfs_tx_pkg::*;
#(
    parameter int unsigned       CLKS_PER_BIT = 4,
    parameter int unsigned       STUFF_RUN    = 6,
    parameter logic [BYTE_W-1:0] SYNC_PATTERN = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_fmt,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              line_p,
    output logic              line_n,
    output logic              drv_en
);
    logic       run;
    logic       bit_end;
    emit_kind_t emit_kind;
    logic       emit_bit;
    line_sym_t  sym;

    usbfs_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .bit_end (bit_end)
    );

    usbfs_tx_ctrl #(.STUFF_RUN(STUFF_RUN), .SYNC_PATTERN(SYNC_PATTERN)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .bit_end   (bit_end),
        .run       (run),
        .emit_kind (emit_kind),
        .emit_bit  (emit_bit)
    );

    usbfs_line_drv line_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .emit_kind (emit_kind),
        .emit_bit  (emit_bit),
        .sym       (sym),
        .oe        (drv_en)
    );

    usbfs_pin_enc enc_i (
        .fmt (pin_fmt),
        .sym (sym),
        .p   (line_p),
        .n   (line_n)
    );
endmodule

// File: rtl/usbfs_tx_checker.sv
module usbfs_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic pin_fmt,
    input logic tx_valid,
    input logic tx_ready,
    input logic line_p,
    input logic line_n,
    input logic drv_en
);
    logic [1:0] pins;
    logic [1:0] prev;
    logic [7:0] hold;

    assign pins = {line_n, line_p};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= 2'b01;
            hold <= '0;
        end else begin
            prev <= pins;
            hold <= (pins != prev) ? 8'd1 : hold + 8'd1;
        end
    end

    p_bit_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((pins != prev) && $past(drv_en)) |-> (hold[1:0] == 2'b00));

    p_eop_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en) |-> ($past(pins) == 2'b01 &&
                           $past(pins, 5) == (pin_fmt ? 2'b00 : 2'b10)));

    p_ready_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> tx_valid);

    p_ready_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |=> !tx_ready);

    p_no_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pin_fmt |-> (pins != 2'b11));

    p_idle_j_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |-> (pins == 2'b01 && !tx_ready));
endmodule

bind usbfs_tx_serializer usbfs_tx_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_fmt  (pin_fmt),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .line_p   (line_p),
    .line_n   (line_n),
    .drv_en   (drv_en)
);

// File: tb/usbfs_tx_serializer_tb_top.sv
module usbfs_tx_serializer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 4;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_fmt = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       line_p;
    logic       line_n;
    logic       drv_en;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ready_cnt = 0;

    logic [7:0] pkt [8];
    int         pkt_len;
    int         exp_sym [512];
    string      exp_req [512];
    int         exp_len;

    usbfs_tx_serializer dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_fmt  (pin_fmt),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .line_p   (line_p),
        .line_n   (line_n),
        .drv_en   (drv_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WATCHDOG) begin
            errors++;
            $display("FAIL watchdog expired after %0d cycles, expected completion", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    always @(negedge clk) if (tx_ready) ready_cnt++;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Symbol codes: 0 = SE0, 1 = J, 2 = K, -1 = illegal
    function automatic int decode(input logic m, input logic n, input logic p);
        if ({n, p} == 2'b01) return 1;
        if (!m) return ({n, p} == 2'b00) ? 2 : 0;
        if ({n, p} == 2'b10) return 2;
        if ({n, p} == 2'b00) return 0;
        return -1;
    endfunction

    function automatic void add_sym(input int s, input string r);
        exp_sym[exp_len] = s;
        exp_req[exp_len] = r;
        exp_len++;
    endfunction

    function automatic void build_expected();
        int lvl = 1;
        int ones = 0;
        exp_len = 0;
        for (int b = 0; b <= pkt_len; b++) begin
            logic [7:0] v = (b == 0) ? 8'h80 : pkt[b-1];
            string r = (b == 0) ? "R2" : "R3";
            for (int i = 0; i < 8; i++) begin
                if (!v[i]) lvl = 3 - lvl;
                add_sym(lvl, r);
                ones = v[i] ? ones + 1 : 0;
                if (ones == 6) begin
                    lvl = 3 - lvl;
                    add_sym(lvl, "R4");
                    ones = 0;
                end
            end
        end
        add_sym(0, "R5");
        add_sym(0, "R5");
        add_sym(1, "R5");
    endfunction

    task automatic drive();
        int idx = 0;
        @(negedge clk);
        tx_valid = 1'b1;
        tx_data  = (pkt_len > 0) ? pkt[0] : 8'h00;
        if (pkt_len == 0) begin
            @(negedge clk);
            tx_valid = 1'b0;
        end else begin
            while (idx < pkt_len) begin
                @(negedge clk);
                if (tx_ready) begin
                    idx++;
                    @(negedge clk);
                    if (idx < pkt_len) tx_data = pkt[idx];
                    else tx_valid = 1'b0;
                end
            end
        end
    endtask

    task automatic monitor();
        int s;
        int first_se0 = exp_len - 3;
        do @(negedge clk); while (!drv_en);
        for (int k = 0; k < exp_len; k++) begin
            s = decode(pin_fmt, line_n, line_p);
            chk(s == exp_sym[k], exp_req[k], $sformatf("symbol %0d first clock", k), s, exp_sym[k]);
            chk(drv_en == 1'b1, "R5", $sformatf("drv_en during symbol %0d", k), int'(drv_en), 1);
            if (k == 0)
                chk({line_n, line_p} == (pin_fmt ? 2'b10 : 2'b00), pin_fmt ? "R8" : "R7",
                    "K encoding", int'({line_n, line_p}), pin_fmt ? 2 : 0);
            if (k == first_se0)
                chk({line_n, line_p} == (pin_fmt ? 2'b00 : 2'b10), pin_fmt ? "R8" : "R7",
                    "SE0 encoding", int'({line_n, line_p}), pin_fmt ? 0 : 2);
            repeat (BIT_CLKS - 1) @(negedge clk);
            s = decode(pin_fmt, line_n, line_p);
            chk(s == exp_sym[k], "R1", $sformatf("symbol %0d last clock", k), s, exp_sym[k]);
            @(negedge clk);
        end
        chk(drv_en == 1'b0, "R5", "drv_en after EOP", int'(drv_en), 0);
        chk({line_n, line_p} == 2'b01, "R5", "line J after EOP", int'({line_n, line_p}), 1);
    endtask

    task automatic run_packet(input logic fmt);
        @(negedge clk);
        pin_fmt   = fmt;
        ready_cnt = 0;
        build_expected();
        fork
            drive();
            monitor();
        join
        chk(ready_cnt == pkt_len, "R6", "ready pulse count", ready_cnt, pkt_len);
        repeat (3) begin
            @(negedge clk);
            chk(!drv_en && !tx_ready && {line_n, line_p} == 2'b01, "R9", "idle state",
                int'({drv_en, tx_ready, line_n, line_p}), 1);
        end
    endtask

    initial begin
        int seed_val;
        seed_val = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        chk(!drv_en && !tx_ready && {line_n, line_p} == 2'b01, "R9", "reset state",
            int'({drv_en, tx_ready, line_n, line_p}), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Directed: plain byte in format 0
        pkt_len = 1; pkt[0] = 8'hA5;
        run_packet(1'b0);
        // Directed: all ones, stuffing within and across bytes (R4)
        pkt_len = 2; pkt[0] = 8'hFF; pkt[1] = 8'hFF;
        run_packet(1'b1);
        // Directed: all zeros, every bit inverts the line (R3)
        pkt_len = 2; pkt[0] = 8'h00; pkt[1] = 8'h00;
        run_packet(1'b0);
        // Directed: stuff bit right before EOP (R4)
        pkt_len = 1; pkt[0] = 8'hFC;
        run_packet(1'b1);
        // Directed: six ones inside a byte then more data
        pkt_len = 2; pkt[0] = 8'h3F; pkt[1] = 8'h01;
        run_packet(1'b0);
        // Directed: no byte offered after sync, early end (R6)
        pkt_len = 0;
        run_packet(1'b1);

        // Seeded random packets
        for (int r = 0; r < 12; r++) begin
            pkt_len = 1 + int'($urandom % 5);
            for (int i = 0; i < pkt_len; i++) pkt[i] = 8'($urandom);
            run_packet(1'($urandom % 2));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule